// File: doc/BRIEF.md
# Command FIFO Transfer Engine

This block carries a command from a host into a shared byte buffer and carries the answer back out. The host sees two things per locality: a status register and a data FIFO window. It makes byte-addressed accesses of one to four bytes, little-endian, that never cross a 32-bit word. Each locality has its own transfer state machine with five states: idle, ready, reception, execution and completion. A command-ready request arms the locality. Bytes written to the FIFO then fill the buffer. The total command length is taken from the command header, and the expect flag tracks whether more bytes are still needed.

A go request hands the collected command to an execution port, which is a plain request/complete handshake. The executor writes its response into the same buffer and pulses done. The host then drains the response through the FIFO window. It can rewind the read pointer with a response-retry request, and a command-ready request returns the locality to ready. The status register reports a dynamic burst count. While a response is pending, that count is the number of response bytes still unread. Otherwise it is the free buffer space.

Which locality is active is decided outside this block. Interrupts are also handled outside; the engine only emits one-cycle event pulses tagged with a locality number.

Top module: `cfe_engine`

## Requirements
- R1: After reset every locality is idle. A 32-bit status read returns the family code in bits 27:26, the buffer depth as burst count in bits 23:8, and zero in all flag bits.
- R2: A command-ready write (status byte 0, bit 6) in idle moves to ready, sets command-ready and pulses the command-ready event. In completion it moves to ready with command-ready set and data-available (bit 4) cleared, pulsing the event only if command-ready was clear.
- R3: A FIFO write in ready moves to reception with valid (bit 7) and expect (bit 3) set. FIFO writes in idle, execution or completion store nothing, so the burst count is unchanged.
- R4: Once more than 5 command bytes have been received, bytes 2..5 form a big-endian total length. Expect stays set while that length exceeds the bytes received and clears when the command is complete.
- R5: A go write (bit 5) is honoured only in reception with expect clear. It then enters execution and pulses `execReq` with `execLen` equal to the bytes received and `execLoc` equal to the locality. Otherwise it has no effect.
- R6: When `execDone` arrives, the owning locality enters completion with valid and data-available set and both offsets at zero. The data-available and status-valid events pulse together.
- R7: FIFO reads in completion return successive response bytes, packed little-endian. Any other byte returns 0xFF. The response length is taken from bytes 2..5 of the buffer. After the last byte only valid remains set, and the status-valid event pulses.
- R8: A response-retry write (bit 1) in completion rewinds the read offset to zero and sets valid and data-available again.
- R9: The burst count is the response length minus the read offset while data-available is set. Otherwise it is the free buffer space, clamped to 0xFF for single-byte status reads.
- R10: Only the active locality can use the status register and the FIFO. Reads from any other locality return all ones, and its writes have no effect.
- R11: A command-ready write in reception aborts at once: the locality goes to ready with command-ready set and the event pulses. In execution it pulses `execCancel`, and the next `execDone` returns the locality to ready with command-ready set instead of completion.
- R12: An access's byte count is cut to the bytes left in its 32-bit word. The FIFO answers at offset 0x24 and at every word from 0x80 to 0xBC. The status register sits at 0x18.
- R13: A write that finds the buffer full clears expect and leaves valid as the only flag, so go becomes allowed.
- R14: The self-test-done flag (bit 2) is set by a done with `execSelfTest` high. It survives all later status updates until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| activeLoc | input | 3 | Locality currently granted; a value at or above the locality count means none |
| busValid | input | 1 | Access strobe, one cycle per access |
| busWrite | input | 1 | 1 = write, 0 = read |
| busLoc | input | 3 | Locality issuing the access |
| busAddr | input | 12 | Byte offset inside the locality window |
| busSize | input | 3 | Access size in bytes, 1 to 4 |
| busWData | input | 32 | Write value, right-aligned |
| busRData | output | 32 | Read value, right-aligned, valid in the access cycle |
| execReq | output | 1 | Pulse: command ready for execution |
| execLen | output | 16 | Command byte count |
| execLoc | output | 3 | Locality that owns the command |
| execCancel | output | 1 | Pulse: cancel the running command |
| rspWe | input | 1 | Executor buffer write strobe |
| rspAddr | input | 16 | Executor buffer byte address |
| rspData | input | 8 | Executor buffer byte |
| execDone | input | 1 | Pulse: execution finished |
| execSelfTest | input | 1 | Self-test completed, qualified by execDone |
| evCmdReady | output | 1 | Event pulse: command-ready |
| evStsValid | output | 1 | Event pulse: status valid |
| evDataAvail | output | 1 | Event pulse: data available |
| evLoc | output | 3 | Locality the event pulses belong to |

## Verification
The bench builds the engine with a buffer depth of 300 bytes, five localities and family code 01. A depth above 255 makes the single-byte burst-count clamp visible. It is also small enough that filling the buffer to the end and overflowing it takes only about 75 word writes. One full command/response round trip covers split header writes, sub-word reads and a retry. The runs also cover both abort paths, writes and reads from an inactive locality, and the overflow case where go is accepted without a complete header length.

// File: rtl/cfe_pkg.sv
package cfe_pkg;
  localparam int PTR_W = 16;

  typedef enum logic [2:0] {
    ST_IDLE, ST_READY, ST_RECV, ST_EXEC, ST_DONE
  } xferState_e;

  localparam int F_VALID  = 7;
  localparam int F_CMDRDY = 6;
  localparam int F_DAV    = 4;
  localparam int F_EXPECT = 3;

  localparam logic [7:0] FL_VALID  = 8'h80;
  localparam logic [7:0] FL_CMDRDY = 8'h40;
  localparam logic [7:0] FL_GO     = 8'h20;
  localparam logic [7:0] FL_DAV    = 8'h10;
  localparam logic [7:0] FL_EXPECT = 8'h08;
  localparam logic [7:0] FL_RETRY  = 8'h02;

  typedef struct packed {
    logic             wrEn;
    logic [2:0]       wrCnt;
    logic [PTR_W-1:0] wrPtr;
    logic [31:0]      wrData;
  } bufStrobe_t;
endpackage

// File: rtl/cfe_buffer.sv
module cfe_buffer
  import cfe_pkg::*;
#(
  parameter int DEPTH = 1024,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic                  clk,
  input  bufStrobe_t            stb,
  input  logic [PTR_W-1:0]      rdPtr,
  input  logic                  rspWe,
  input  logic [PTR_W-1:0]      rspAddr,
  input  logic [7:0]            rspData,
  output logic [31:0]           hdrLen,
  output logic [3:0][7:0]       rdBytes
);
  localparam logic [PTR_W-1:0] DEPTH_P = PTR_W'(DEPTH);

  logic [7:0]       mem [DEPTH];
  logic [PTR_W-1:0] wIdx [4];
  logic [3:0]       wOk;
  logic [PTR_W-1:0] rIdx [4];
  logic [7:0]       hb [4];

  always_comb begin
    for (int k = 0; k < 4; k++) begin
      wIdx[k] = stb.wrPtr + PTR_W'(k);
      wOk[k]  = stb.wrEn && (3'(k) < stb.wrCnt) && (wIdx[k] < DEPTH_P);
      rIdx[k] = rdPtr + PTR_W'(k);
      rdBytes[k] = (rIdx[k] < DEPTH_P) ? mem[rIdx[k][AW-1:0]] : 8'hFF;
    end
  end

  // header bytes 2..5, with bytes of the write in flight merged in
  always_comb begin
    for (int i = 0; i < 4; i++) begin
      hb[i] = mem[i + 2];
      for (int k = 0; k < 4; k++) begin
        if (wOk[k] && wIdx[k] == PTR_W'(i + 2)) hb[i] = stb.wrData[8*k +: 8];
      end
    end
    hdrLen = {hb[0], hb[1], hb[2], hb[3]};
  end

  always_ff @(posedge clk) begin
    for (int k = 0; k < 4; k++) begin
      if (wOk[k]) mem[wIdx[k][AW-1:0]] <= stb.wrData[8*k +: 8];
    end
    if (rspWe && rspAddr < DEPTH_P) mem[rspAddr[AW-1:0]] <= rspData;
  end
endmodule

// File: rtl/cfe_ctrl.sv
module cfe_ctrl
  import cfe_pkg::*;
#(
  parameter int         NUM_LOC = 5,
  parameter int         DEPTH   = 1024,
  parameter logic [1:0] FAMILY  = 2'b01,
  localparam int        LOC_W   = $clog2(NUM_LOC + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [LOC_W-1:0] activeLoc,
  input  logic             busValid,
  input  logic             busWrite,
  input  logic [LOC_W-1:0] busLoc,
  input  logic [11:0]      busAddr,
  input  logic [2:0]       busSize,
  input  logic [31:0]      busWData,
  output logic [31:0]      busRData,
  input  logic [31:0]      hdrLen,
  input  logic [3:0][7:0]  rdBytes,
  output bufStrobe_t       stb,
  output logic [PTR_W-1:0] rdPtr,
  output logic             execReq,
  output logic [PTR_W-1:0] execLen,
  output logic [LOC_W-1:0] execLoc,
  output logic             execCancel,
  input  logic             execDone,
  input  logic             execSelfTest,
  output logic             evCmdReady,
  output logic             evStsValid,
  output logic             evDataAvail,
  output logic [LOC_W-1:0] evLoc
);
  localparam logic [PTR_W-1:0] DEPTH_P = PTR_W'(DEPTH);
  localparam logic [31:0]      DEPTH_W = 32'(DEPTH);

  xferState_e       st [NUM_LOC], stN [NUM_LOC];
  logic [7:0]       flg [NUM_LOC], flgN [NUM_LOC];
  logic [PTR_W-1:0] wOff [NUM_LOC], wOffN [NUM_LOC];
  logic [PTR_W-1:0] rOff [NUM_LOC], rOffN [NUM_LOC];
  logic             stDone, stDoneN, abortPend, abortN;
  logic [LOC_W-1:0] owner, ownerN, evLocN;
  logic             reqN, cancelN, evCN, evSN, evDN;
  logic [PTR_W-1:0] lenN;

  logic [1:0]       lane;
  logic [2:0]       maxB, nBytes, nW, cnt;
  logic             isSts, isFifo, locOk, ovf;
  logic [LOC_W-1:0] cur;
  logic [PTR_W-1:0] rspLen, burst, freeSp, room, wNew;
  logic [31:0]      stsWord;
  logic [7:0]       cmd, f, rb;

  assign lane   = busAddr[1:0];
  assign maxB   = 3'd4 - {1'b0, lane};
  assign nBytes = (busSize > maxB) ? maxB : busSize;
  assign isSts  = busAddr[11:2] == 10'h006;
  assign isFifo = busAddr[11:2] == 10'h009 ||
                  (busAddr[11:2] >= 10'h020 && busAddr[11:2] <= 10'h02F);
  assign locOk  = busLoc == activeLoc && busLoc < LOC_W'(NUM_LOC);
  assign cur    = locOk ? busLoc : '0;
  assign rspLen = (hdrLen > DEPTH_W) ? DEPTH_P : hdrLen[PTR_W-1:0];
  assign rdPtr  = rOff[cur];
  assign execLoc = owner;

  always_comb begin
    stN = st; flgN = flg; wOffN = wOff; rOffN = rOff;
    stDoneN = stDone; abortN = abortPend; ownerN = owner;
    reqN = 1'b0; lenN = execLen; cancelN = 1'b0;
    evCN = 1'b0; evSN = 1'b0; evDN = 1'b0; evLocN = evLoc;
    stb = '0; busRData = '1; cnt = '0; cmd = '0; f = '0; nW = '0;
    ovf = 1'b0; rb = '0; room = '0; wNew = '0;
    freeSp = DEPTH_P - wOff[cur];
    if (flg[cur][F_DAV]) burst = rspLen - rOff[cur];
    else if (busSize == 3'd1 && freeSp > PTR_W'(255)) burst = PTR_W'(255);
    else burst = freeSp;
    stsWord = {4'b0, FAMILY, 2'b0, burst, flg[cur] | {5'b0, stDone, 2'b0}};

    if (busValid && locOk) begin
      if (!busWrite && isSts) begin
        busRData = stsWord >> {lane, 3'b000};
      end else if (!busWrite && isFifo) begin
        busRData = '0;
        for (int k = 0; k < 4; k++) begin
          if (3'(k) < nBytes) begin
            if (st[cur] == ST_DONE && flg[cur][F_DAV] &&
                (rOff[cur] + PTR_W'(k)) < rspLen) begin
              rb = rdBytes[k];
              cnt = cnt + 3'd1;
            end else begin
              rb = 8'hFF;
            end
            busRData[8*k +: 8] = rb;
          end
        end
        rOffN[cur] = rOff[cur] + PTR_W'(cnt);
        if (cnt != 3'd0 && rOffN[cur] >= rspLen) begin
          flgN[cur] = FL_VALID; evSN = 1'b1; evLocN = cur;
        end
      end else if (busWrite && isSts) begin
        cmd = (lane == 2'd0) ? (busWData[7:0] & (FL_CMDRDY | FL_GO | FL_RETRY)) : 8'h00;
        case (cmd)
          FL_CMDRDY: begin
            case (st[cur])
              ST_IDLE: begin
                stN[cur] = ST_READY; flgN[cur] = FL_CMDRDY; evCN = 1'b1; evLocN = cur;
              end
              ST_READY: begin
                wOffN[cur] = '0; rOffN[cur] = '0;
              end
              ST_RECV: begin
                stN[cur] = ST_READY; flgN[cur] = FL_CMDRDY;
                wOffN[cur] = '0; rOffN[cur] = '0; evCN = 1'b1; evLocN = cur;
              end
              ST_EXEC: begin
                cancelN = 1'b1; abortN = 1'b1;
              end
              default: begin
                stN[cur] = ST_READY; wOffN[cur] = '0; rOffN[cur] = '0;
                if (!flg[cur][F_CMDRDY]) begin
                  flgN[cur] = FL_CMDRDY; evCN = 1'b1; evLocN = cur;
                end else begin
                  flgN[cur] = flg[cur] & ~FL_DAV;
                end
              end
            endcase
          end
          FL_GO: begin
            if (st[cur] == ST_RECV && !flg[cur][F_EXPECT]) begin
              stN[cur] = ST_EXEC; reqN = 1'b1; lenN = wOff[cur]; ownerN = cur;
            end
          end
          FL_RETRY: begin
            if (st[cur] == ST_DONE) begin
              rOffN[cur] = '0; flgN[cur] = FL_VALID | FL_DAV;
            end
          end
          default: ;
        endcase
      end else if (busWrite && isFifo && (st[cur] == ST_READY || st[cur] == ST_RECV)) begin
        f = (st[cur] == ST_READY) ? (FL_VALID | FL_EXPECT) : flg[cur];
        stN[cur] = ST_RECV;
        wNew = wOff[cur];
        if (f[F_EXPECT]) begin
          room = DEPTH_P - wOff[cur];
          ovf  = PTR_W'(nBytes) > room;
          nW   = ovf ? room[2:0] : nBytes;
          stb.wrEn = 1'b1; stb.wrCnt = nW; stb.wrPtr = wOff[cur]; stb.wrData = busWData;
          wNew = wOff[cur] + PTR_W'(nW);
          if (ovf) f = FL_VALID;
          if (wNew > PTR_W'(5) && f[F_EXPECT]) begin
            if (!f[F_VALID]) begin evSN = 1'b1; evLocN = cur; end
            f = (hdrLen > {{(32-PTR_W){1'b0}}, wNew}) ? (FL_VALID | FL_EXPECT) : FL_VALID;
          end
        end
        flgN[cur] = f; wOffN[cur] = wNew;
      end
    end

    if (execDone) begin
      stDoneN = stDone | execSelfTest;
      wOffN[owner] = '0; rOffN[owner] = '0; evLocN = owner;
      if (abortPend) begin
        stN[owner] = ST_READY; flgN[owner] = FL_CMDRDY; evCN = 1'b1; abortN = 1'b0;
      end else begin
        stN[owner] = ST_DONE; flgN[owner] = FL_VALID | FL_DAV; evDN = 1'b1; evSN = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_LOC; i++) begin
        st[i] <= ST_IDLE; flg[i] <= '0; wOff[i] <= '0; rOff[i] <= '0;
      end
      stDone <= 1'b0; abortPend <= 1'b0; owner <= '0;
      execReq <= 1'b0; execLen <= '0; execCancel <= 1'b0;
      evCmdReady <= 1'b0; evStsValid <= 1'b0; evDataAvail <= 1'b0; evLoc <= '0;
    end else begin
      st <= stN; flg <= flgN; wOff <= wOffN; rOff <= rOffN;
      stDone <= stDoneN; abortPend <= abortN; owner <= ownerN;
      execReq <= reqN; execLen <= lenN; execCancel <= cancelN;
      evCmdReady <= evCN; evStsValid <= evSN; evDataAvail <= evDN; evLoc <= evLocN;
    end
  end
endmodule

// File: rtl/cfe_engine.sv
module cfe_engine
  import cfe_pkg::*;
#(
  parameter int         NUM_LOC = 5,
  parameter int         DEPTH   = 1024,
  parameter logic [1:0] FAMILY  = 2'b01,
  localparam int        LOC_W   = $clog2(NUM_LOC + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [LOC_W-1:0] activeLoc,
  input  logic             busValid,
  input  logic             busWrite,
  input  logic [LOC_W-1:0] busLoc,
  input  logic [11:0]      busAddr,
  input  logic [2:0]       busSize,
  input  logic [31:0]      busWData,
  output logic [31:0]      busRData,
  output logic             execReq,
  output logic [PTR_W-1:0] execLen,
  output logic [LOC_W-1:0] execLoc,
  output logic             execCancel,
  input  logic             rspWe,
  input  logic [PTR_W-1:0] rspAddr,
  input  logic [7:0]       rspData,
  input  logic             execDone,
  input  logic             execSelfTest,
  output logic             evCmdReady,
  output logic             evStsValid,
  output logic             evDataAvail,
  output logic [LOC_W-1:0] evLoc
);
  bufStrobe_t       stb;
  logic [PTR_W-1:0] rdPtr;
  logic [31:0]      hdrLen;
  logic [3:0][7:0]  rdBytes;

  cfe_ctrl #(.NUM_LOC(NUM_LOC), .DEPTH(DEPTH), .FAMILY(FAMILY)) u_ctrl (
    .clk, .rstN, .activeLoc, .busValid, .busWrite, .busLoc, .busAddr,
    .busSize, .busWData, .busRData, .hdrLen, .rdBytes, .stb, .rdPtr,
    .execReq, .execLen, .execLoc, .execCancel, .execDone, .execSelfTest,
    .evCmdReady, .evStsValid, .evDataAvail, .evLoc
  );

  cfe_buffer #(.DEPTH(DEPTH)) u_buf (
    .clk, .stb, .rdPtr, .rspWe, .rspAddr, .rspData, .hdrLen, .rdBytes
  );
endmodule

// File: rtl/cfe_engine_chk.sv
module cfe_engine_chk #(
  parameter int NUM_LOC = 5,
  parameter int LOC_W   = 3
) (
  input logic             clk,
  input logic             rstN,
  input logic [LOC_W-1:0] activeLoc,
  input logic             busValid,
  input logic             busWrite,
  input logic [LOC_W-1:0] busLoc,
  input logic [31:0]      busRData,
  input logic             execReq,
  input logic [15:0]      execLen,
  input logic             execCancel,
  input logic             execDone,
  input logic             evCmdReady,
  input logic             evStsValid,
  input logic             evDataAvail,
  input logic [LOC_W-1:0] evLoc
);
  logic busy;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) busy <= 1'b0;
    else if (execReq) busy <= 1'b1;
    else if (execDone) busy <= 1'b0;
  end

  // R6: a data-available event always comes with a status-valid event
  p_dav_with_sv_r6: assert property (@(posedge clk) disable iff (!rstN)
    evDataAvail |-> evStsValid);

  // R4: a command can only be submitted once its header length has been seen
  p_cmd_len_min_r4: assert property (@(posedge clk) disable iff (!rstN)
    execReq |-> execLen >= 16'd6);

  // R10: reads from a locality that is not active return all ones
  p_inactive_read_r10: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && !busWrite && busLoc != activeLoc) |-> busRData == 32'hFFFF_FFFF);

  // R11: cancel is only issued while a submitted command is outstanding
  p_cancel_busy_r11: assert property (@(posedge clk) disable iff (!rstN)
    execCancel |-> busy);

  // R2: every event carries a legal locality tag
  p_ev_loc_r2: assert property (@(posedge clk) disable iff (!rstN)
    (evCmdReady || evStsValid || evDataAvail) |-> evLoc < LOC_W'(NUM_LOC));
endmodule

bind cfe_engine cfe_engine_chk #(.NUM_LOC(NUM_LOC), .LOC_W(LOC_W)) u_chk (
  .clk(clk), .rstN(rstN), .activeLoc(activeLoc), .busValid(busValid),
  .busWrite(busWrite), .busLoc(busLoc), .busRData(busRData),
  .execReq(execReq), .execLen(execLen), .execCancel(execCancel),
  .execDone(execDone), .evCmdReady(evCmdReady), .evStsValid(evStsValid),
  .evDataAvail(evDataAvail), .evLoc(evLoc)
);

// File: tb/test_cfe_engine.sv
`timescale 1ns/1ps
module test_cfe_engine;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  activeLoc = 3'd1;
  logic        busValid = 1'b0, busWrite = 1'b0;
  logic [2:0]  busLoc = 3'd0;
  logic [11:0] busAddr = '0;
  logic [2:0]  busSize = '0;
  logic [31:0] busWData = '0;
  logic [31:0] busRData;
  logic        execReq, execCancel;
  logic [15:0] execLen;
  logic [2:0]  execLoc;
  logic        rspWe = 1'b0;
  logic [15:0] rspAddr = '0;
  logic [7:0]  rspData = '0;
  logic        execDone = 1'b0, execSelfTest = 1'b0;
  logic        evCmdReady, evStsValid, evDataAvail;
  logic [2:0]  evLoc;

  int nChk = 0, nBad = 0;
  logic cEvC, cEvS, cEvD, cReq, cCancel;
  logic [15:0] cLen;
  logic [2:0]  cLoc;
  logic [31:0] rd;
  logic [7:0]  rsp [12] = '{8'hC4, 8'h00, 8'h00, 8'h00, 8'h00, 8'h0C,
                            8'hAA, 8'hBB, 8'hCC, 8'hDD, 8'hEE, 8'hFF};

  always #4 clk = ~clk;

  cfe_engine #(.NUM_LOC(5), .DEPTH(300), .FAMILY(2'b01)) i_cfe_engine (
    .clk, .rstN, .activeLoc, .busValid, .busWrite, .busLoc, .busAddr,
    .busSize, .busWData, .busRData, .execReq, .execLen, .execLoc,
    .execCancel, .rspWe, .rspAddr, .rspData, .execDone, .execSelfTest,
    .evCmdReady, .evStsValid, .evDataAvail, .evLoc
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic capture();
    cEvC = evCmdReady; cEvS = evStsValid; cEvD = evDataAvail;
    cReq = execReq; cLen = execLen; cLoc = execLoc; cCancel = execCancel;
  endtask

  task automatic busOp(input logic wr, input logic [2:0] loc, input logic [11:0] addr,
                       input logic [2:0] sz, input logic [31:0] wd, output logic [31:0] r);
    @(negedge clk);
    busValid = 1'b1; busWrite = wr; busLoc = loc; busAddr = addr;
    busSize = sz; busWData = wd;
    #1 r = busRData;
    @(posedge clk); #1;
    capture();
    busValid = 1'b0;
  endtask

  task automatic wr(input logic [11:0] addr, input logic [2:0] sz, input logic [31:0] wd);
    logic [31:0] dummy;
    busOp(1'b1, activeLoc, addr, sz, wd, dummy);
  endtask

  task automatic rdReg(input logic [11:0] addr, input logic [2:0] sz, output logic [31:0] r);
    busOp(1'b0, activeLoc, addr, sz, 32'h0, r);
  endtask

  task automatic respond(input int n, input logic selfTest);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      rspWe = 1'b1; rspAddr = 16'(i); rspData = rsp[i];
    end
    @(negedge clk);
    rspWe = 1'b0; execDone = 1'b1; execSelfTest = selfTest;
    @(posedge clk); #1;
    capture();
    execDone = 1'b0; execSelfTest = 1'b0;
  endtask

  task automatic tResetState();
    rdReg(12'h018, 3'd4, rd);   chk("R1 reset status word", rd, 32'h0401_2C00);
    rdReg(12'h024, 3'd4, rd);   chk("R7 FIFO read in idle", rd, 32'hFFFF_FFFF);
    wr(12'h024, 3'd4, 32'h1234_5678);
    rdReg(12'h018, 3'd4, rd);   chk("R3 FIFO write in idle dropped", rd, 32'h0401_2C00);
  endtask

  task automatic tInactive();
    busOp(1'b0, 3'd2, 12'h018, 3'd4, 32'h0, rd);
    chk("R10 inactive status read", rd, 32'hFFFF_FFFF);
    busOp(1'b1, 3'd2, 12'h018, 3'd1, 32'h40, rd);
    chk("R10 inactive write no event", {31'b0, cEvC}, 32'h0);
    activeLoc = 3'd2;
    rdReg(12'h018, 3'd4, rd);   chk("R10 inactive write left idle", rd, 32'h0401_2C00);
    activeLoc = 3'd1;
  endtask

  task automatic tCmdReady();
    wr(12'h018, 3'd1, 32'h40);
    chk("R2 idle->ready event", {31'b0, cEvC}, 32'h1);
    chk("R2 event locality", {29'b0, evLoc}, 32'h1);
    rdReg(12'h018, 3'd4, rd);   chk("R2 ready status", rd, 32'h0401_2C40);
  endtask

  task automatic tCommandLoad();
    wr(12'h024, 3'd4, 32'h0000_0180);
    rdReg(12'h018, 3'd4, rd);   chk("R3 reception flags", rd, 32'h0401_2888);
    wr(12'h024, 3'd2, 32'h0000_0A00);
    rdReg(12'h018, 3'd4, rd);   chk("R4 expect kept below length", rd, 32'h0401_2688);
    wr(12'h018, 3'd1, 32'h20);
    chk("R5 go ignored while expecting", {31'b0, cReq}, 32'h0);
    wr(12'h080, 3'd4, 32'h4401_0000);
    rdReg(12'h018, 3'd4, rd);   chk("R4 expect cleared at length", rd, 32'h0401_2280);
    wr(12'h018, 3'd1, 32'h20);
    chk("R5 go submits", {31'b0, cReq}, 32'h1);
    chk("R5 exec length", {16'b0, cLen}, 32'd10);
    chk("R5 exec locality", {29'b0, cLoc}, 32'd1);
    wr(12'h024, 3'd4, 32'hDEAD_BEEF);
    rdReg(12'h018, 3'd4, rd);   chk("R3 write in execution dropped", rd, 32'h0401_2280);
  endtask

  task automatic tResponse();
    respond(12, 1'b1);
    chk("R6 data-available event", {31'b0, cEvD}, 32'h1);
    chk("R6 status-valid event", {31'b0, cEvS}, 32'h1);
    rdReg(12'h018, 3'd4, rd);   chk("R6 R14 completion status", rd, 32'h0400_0C94);
    rdReg(12'h024, 3'd4, rd);   chk("R7 first response word", rd, 32'h0000_00C4);
    rdReg(12'h018, 3'd4, rd);   chk("R9 burst after read", rd, 32'h0400_0894);
    rdReg(12'h026, 3'd4, rd);   chk("R12 read clamped to word", rd, 32'h0000_0C00);
    wr(12'h018, 3'd1, 32'h02);
    rdReg(12'h018, 3'd4, rd);   chk("R8 retry rewinds", rd, 32'h0400_0C94);
    rdReg(12'h024, 3'd4, rd);   chk("R8 reread first word", rd, 32'h0000_00C4);
    rdReg(12'h084, 3'd4, rd);   chk("R7 R12 wide window word", rd, 32'hBBAA_0C00);
    rdReg(12'h088, 3'd4, rd);   chk("R7 last word", rd, 32'hFFEE_DDCC);
    chk("R7 last byte event", {31'b0, cEvS}, 32'h1);
    rdReg(12'h018, 3'd4, rd);   chk("R7 valid only after drain", rd, 32'h0401_2C84);
    rdReg(12'h024, 3'd4, rd);   chk("R7 read past end", rd, 32'hFFFF_FFFF);
    wr(12'h018, 3'd1, 32'h40);
    chk("R2 completion->ready event", {31'b0, cEvC}, 32'h1);
    rdReg(12'h018, 3'd4, rd);   chk("R2 R14 ready after completion", rd, 32'h0401_2C44);
  endtask

  task automatic tAbortRecv();
    wr(12'h024, 3'd4, 32'h0000_0180);
    rdReg(12'h018, 3'd4, rd);   chk("R3 reception again", rd, 32'h0401_288C);
    wr(12'h018, 3'd1, 32'h40);
    chk("R11 abort event", {31'b0, cEvC}, 32'h1);
    rdReg(12'h018, 3'd4, rd);   chk("R11 aborted to ready", rd, 32'h0401_2C44);
  endtask

  task automatic tAbortExec();
    wr(12'h024, 3'd4, 32'h0000_0180);
    wr(12'h024, 3'd2, 32'h0000_0600);
    wr(12'h018, 3'd1, 32'h20);
    chk("R5 short command submits", {16'b0, cLen}, 32'd6);
    wr(12'h018, 3'd1, 32'h40);
    chk("R11 cancel pulse", {31'b0, cCancel}, 32'h1);
    respond(0, 1'b0);
    chk("R11 done after abort gives cmd-ready", {29'b0, cEvC, cEvD, cEvS}, 32'h4);
    rdReg(12'h018, 3'd4, rd);   chk("R11 ready after cancel", rd, 32'h0401_2C44);
  endtask

  task automatic tClamp();
    rdReg(12'h019, 3'd1, rd);   chk("R9 single-byte clamp", {24'b0, rd[7:0]}, 32'h0000_00FF);
    rdReg(12'h019, 3'd2, rd);   chk("R9 two-byte burst", {16'b0, rd[15:0]}, 32'h0000_012C);
  endtask

  task automatic tOverflow();
    wr(12'h024, 3'd4, 32'h0000_0180);
    wr(12'h024, 3'd4, 32'h0000_FFFF);
    for (int i = 0; i < 73; i++) wr(12'h080, 3'd4, 32'h0);
    rdReg(12'h018, 3'd4, rd);   chk("R13 buffer full still expecting", rd, 32'h0400_008C);
    wr(12'h024, 3'd4, 32'h0);
    rdReg(12'h018, 3'd4, rd);   chk("R13 overflow clears expect", rd, 32'h0400_0084);
    wr(12'h018, 3'd1, 32'h20);
    chk("R13 go after overflow", {16'b0, cLen}, 32'd300);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    tResetState();
    tInactive();
    tCmdReady();
    tCommandLoad();
    tResponse();
    tAbortRecv();
    tAbortExec();
    tClamp();
    tOverflow();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    nChk++; nBad++;
    $display("FAIL watchdog R1..all not finished actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end
endmodule